// File: doc/BRIEF.md
# Per-Processor Compare Timer Interrupt

This block keeps one free-running counter that all processors share, and gives each processor a compare register. When the counter reaches a processor's compare value, that processor's compare-pending bit is set. The bit stays set until software writes the compare register again. A pending bit that is enabled by its mask bit and routed by its pin map drives one of that processor's CPU interrupt pins. Each pin output is ORed with an external input for the same processor and pin, so that interrupts from shared sources can share the pin.

Software reaches the block through a single-cycle register port. The port carries the index of the accessing processor. A global configuration register holds a halt bit for the counter. The counter can be written only while it is halted. The upper counter word and a read-only user copy of the counter are also mapped. Each processor has a bank of registers. It reaches its own bank through a local window. A remote window reaches the bank of the processor named in the accessor's remote-select register, so one processor can program another processor's timer.

Top module: `pcpu_cmp_timer`

## Requirements
- R1: After reset the following values hold. The counter starts at 0 and runs. Every compare register reads 0xFFFFFFFF. Pending reads 0. The mask reads 0x32. The pin map reads 0x80000000 (route flag in bit 31, pin 0). The remote-select register reads 0.
- R2: The halt bit (bit 0 of the configuration register at address 0x00) freezes the counter when it is 1. When it is 0, the counter advances by one on every clock.
- R3: A write to the counter (address 0x01) loads the counter only if the halt bit was 1 in that cycle. Otherwise the write is ignored and the counter keeps counting.
- R4: The upper counter word (address 0x02) always reads 0 and ignores writes. The user copy (address 0x03) reads the counter, and writes to it have no effect.
- R5: When the counter equals a processor's compare value, that processor's pending bit (bit 1 of the pending register) is set one clock later. It stays set.
- R6: Output irq_o[p*NUM_PINS+k] is driven by processor p's timer when four conditions hold: pending is set, mask bit 1 is set, the route flag is set, and the pin field (bits 5:0 of the map) equals k.
- R7: A write to a compare register (window offset 7) clears that processor's pending bit. The timer's drive of its pin drops on the next clock.
- R8: The mask (offset 1) is read-only. At offset 2, each 1 bit in the written data clears the matching bit of the 6-bit mask. At offset 3, each 1 bit sets the matching bit.
- R9: A pin-map write (offset 4) is ignored if its pin field is larger than NUM_PINS-1.
- R10: A remote-select write (offset 5) is ignored if the value is NUM_PROC or larger. Accesses in the remote window (0x20+offset) act on the processor that the accessor's remote-select register names. The local window is at 0x10+offset.
- R11: The identity register (offset 6) returns the index of the processor that the window targets. In the local window this is the accessing processor.
- R12: Each irq_o bit is the OR of the timer's drive for that bit and shared_irq_i of the same index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_id_i | input | PROC_W | Index of the processor making the access |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 6 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i and proc_id_i, combinational |
| shared_irq_i | input | NUM_PROC*NUM_PINS | Shared-source requests, processor-major |
| irq_o | output | NUM_PROC*NUM_PINS | CPU pin requests, processor-major |

## Verification
The assertions make three assumptions about the inputs. At most one write occurs per cycle. proc_id_i is always below NUM_PROC. Inputs change away from the clock edge, so a write's effect can be traced to a single edge. The bench meets these assumptions because it drives every input on the falling edge and issues writes back to back only where a test needs them. It uses only processor indices 0 and 1.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int          DATA_W    = 32;
    localparam int          MASK_W    = 6;
    localparam logic [5:0]  MASK_RST  = 6'h32;
    localparam int          CMP_BIT   = 1;
    localparam int          FLAG_BIT  = 31;
    localparam int          PIN_FW    = 6;

    localparam logic [5:0]  A_CFG     = 6'h00;
    localparam logic [5:0]  A_CNT_LO  = 6'h01;
    localparam logic [5:0]  A_CNT_HI  = 6'h02;
    localparam logic [5:0]  A_CNT_USR = 6'h03;

    typedef enum logic [2:0] {
        OFF_PEND  = 3'd0,
        OFF_MASK  = 3'd1,
        OFF_MCLR  = 3'd2,
        OFF_MSET  = 3'd3,
        OFF_CMAP  = 3'd4,
        OFF_OTHER = 3'd5,
        OFF_IDENT = 3'd6,
        OFF_CMP   = 3'd7
    } off_e;
endpackage

// File: rtl/ptmr_counter.sv
module ptmr_counter
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cnt_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              stop_o,
    output logic [CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        logic             stop;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.stop) begin
            if (cnt_we_i) st_d.cnt = wdata_i[CNT_W-1:0];
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (cfg_we_i) st_d.stop = wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stop_o = st_q.stop;
    assign cnt_o  = st_q.cnt;

    // R2: running counter advances by one each clock
    a_r2_runs: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_o |=> cnt_o == $past(cnt_o) + CNT_W'(1));

    // R2/R3: halted counter moves only through a counter write
    a_r2_halted: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o && !cnt_we_i |=> $stable(cnt_o));

    // R3: a write while halted loads the value
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o && cnt_we_i |=> cnt_o == $past(wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/ptmr_unit.sv
module ptmr_unit
    import ptmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_PROC = 2,
    parameter int NUM_PINS = 6,
    parameter int PROC_W   = 1,
    parameter int PIN_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                sel_i,
    input  off_e                off_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                pend_o,
    output logic [MASK_W-1:0]   mask_o,
    output logic                flag_o,
    output logic [PIN_W-1:0]    pin_o,
    output logic [PROC_W-1:0]   other_o,
    output logic [CNT_W-1:0]    cmp_o,
    output logic [NUM_PINS-1:0] tirq_o
);
    typedef struct packed {
        logic              pend;
        logic [MASK_W-1:0] mask;
        logic              flag;
        logic [PIN_W-1:0]  pin;
        logic [PROC_W-1:0] other;
        logic [CNT_W-1:0]  cmp;
    } unit_t;

    unit_t st_d, st_q;
    logic  pin_ok, other_ok;

    assign pin_ok   = 32'(wdata_i[PIN_FW-1:0]) < 32'(NUM_PINS);
    assign other_ok = wdata_i < 32'(NUM_PROC);

    always_comb begin
        st_d = st_q;
        if (cnt_i == st_q.cmp) st_d.pend = 1'b1;
        if (sel_i) begin
            case (off_i)
                OFF_MCLR:  st_d.mask = st_q.mask & ~wdata_i[MASK_W-1:0];
                OFF_MSET:  st_d.mask = st_q.mask | wdata_i[MASK_W-1:0];
                OFF_CMAP:  if (pin_ok) begin
                               st_d.flag = wdata_i[FLAG_BIT];
                               st_d.pin  = wdata_i[PIN_W-1:0];
                           end
                OFF_OTHER: if (other_ok) st_d.other = wdata_i[PROC_W-1:0];
                OFF_CMP:   begin
                               st_d.cmp  = wdata_i[CNT_W-1:0];
                               st_d.pend = 1'b0;
                           end
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mask  <= MASK_RST;
            st_q.flag  <= 1'b1;
            st_q.cmp   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o  = st_q.pend;
    assign mask_o  = st_q.mask;
    assign flag_o  = st_q.flag;
    assign pin_o   = st_q.pin;
    assign other_o = st_q.other;
    assign cmp_o   = st_q.cmp;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        assign tirq_o[k] = st_q.pend & st_q.mask[CMP_BIT] & st_q.flag
                           & (st_q.pin == PIN_W'(k));
    end

    // R5: a match without a compare write leaves pending set
    a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_i == cmp_o && !(sel_i && off_i == OFF_CMP) |=> pend_o);

    // R7: a compare write clears pending
    a_r7_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && off_i == OFF_CMP |=> !pend_o);

    // R8: clear alias removes every written bit
    a_r8_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && off_i == OFF_MCLR |=> (mask_o & $past(wdata_i[MASK_W-1:0])) == '0);

    // R9: out-of-range pin keeps the map
    a_r9_bad_pin_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && off_i == OFF_CMAP && !pin_ok |=> $stable(pin_o) && $stable(flag_o));

    // R10: out-of-range remote select keeps the old value
    a_r10_bad_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && off_i == OFF_OTHER && !other_ok |=> $stable(other_o));

    // R6: the timer drives at most one pin
    a_r6_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tirq_o));
endmodule

// File: rtl/pcpu_cmp_timer.sv
module pcpu_cmp_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_PROC = 2,
    parameter int NUM_PINS = 6,
    parameter int PROC_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PROC_W-1:0]            proc_id_i,
    input  logic                         wr_en_i,
    input  logic [5:0]                   addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o,
    input  logic [NUM_PROC*NUM_PINS-1:0] shared_irq_i,
    output logic [NUM_PROC*NUM_PINS-1:0] irq_o
);
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic              stop;
    logic [CNT_W-1:0]  cnt;
    logic              win_loc, win_oth;
    logic [PROC_W-1:0] target;
    off_e              off;

    logic              pend_a  [NUM_PROC];
    logic [MASK_W-1:0] mask_a  [NUM_PROC];
    logic              flag_a  [NUM_PROC];
    logic [PIN_W-1:0]  pin_a   [NUM_PROC];
    logic [PROC_W-1:0] other_a [NUM_PROC];
    logic [CNT_W-1:0]  cmp_a   [NUM_PROC];
    logic [NUM_PROC*NUM_PINS-1:0] tirq;

    assign win_loc = (addr_i[5:4] == 2'b01) && !addr_i[3];
    assign win_oth = (addr_i[5:4] == 2'b10) && !addr_i[3];
    assign target  = win_oth ? other_a[proc_id_i] : proc_id_i;
    assign off     = off_e'(addr_i[2:0]);

    ptmr_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we_i (wr_en_i && addr_i == A_CFG),
        .cnt_we_i (wr_en_i && addr_i == A_CNT_LO),
        .wdata_i  (wdata_i),
        .stop_o   (stop),
        .cnt_o    (cnt)
    );

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_unit
        ptmr_unit #(
            .CNT_W(CNT_W), .NUM_PROC(NUM_PROC), .NUM_PINS(NUM_PINS),
            .PROC_W(PROC_W), .PIN_W(PIN_W)
        ) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_i   (cnt),
            .sel_i   (wr_en_i && (win_loc || win_oth) && target == PROC_W'(p)),
            .off_i   (off),
            .wdata_i (wdata_i),
            .pend_o  (pend_a[p]),
            .mask_o  (mask_a[p]),
            .flag_o  (flag_a[p]),
            .pin_o   (pin_a[p]),
            .other_o (other_a[p]),
            .cmp_o   (cmp_a[p]),
            .tirq_o  (tirq[p*NUM_PINS +: NUM_PINS])
        );
    end

    assign irq_o = tirq | shared_irq_i;

    always_comb begin
        rdata_o = '0;
        if (win_loc || win_oth) begin
            case (off)
                OFF_PEND:  rdata_o[CMP_BIT] = pend_a[target];
                OFF_MASK:  rdata_o = DATA_W'(mask_a[target]);
                OFF_CMAP:  begin
                               rdata_o = DATA_W'(pin_a[target]);
                               rdata_o[FLAG_BIT] = flag_a[target];
                           end
                OFF_OTHER: rdata_o = DATA_W'(other_a[target]);
                OFF_IDENT: rdata_o = DATA_W'(target);
                OFF_CMP:   rdata_o = DATA_W'(cmp_a[target]);
                default:   rdata_o = '0;
            endcase
        end else begin
            case (addr_i)
                A_CFG:     rdata_o[0] = stop;
                A_CNT_LO:  rdata_o = DATA_W'(cnt);
                A_CNT_USR: rdata_o = DATA_W'(cnt);
                default:   rdata_o = '0;
            endcase
        end
    end

    // R12: a shared request always reaches its pin
    a_r12_shared_or: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & shared_irq_i) == shared_irq_i);

    // R4: upper counter word reads zero
    a_r4_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr_i == A_CNT_HI |-> rdata_o == '0);
endmodule

// File: tb/sim_pcpu_cmp_timer.sv
module sim_pcpu_cmp_timer;
    localparam int NP = 2;
    localparam int NK = 6;
    localparam logic [5:0] L = 6'h10;
    localparam logic [5:0] O = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  proc_id = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP*NK-1:0] shared_irq = '0;
    logic [NP*NK-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pcpu_cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .proc_id_i(proc_id), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .shared_irq_i(shared_irq), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int p, input logic [5:0] a, input logic [31:0] d);
        proc_id = 1'(p); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int p, input logic [5:0] a, output logic [31:0] v);
        proc_id = 1'(p); addr = a;
        #1 v = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v, v2;
        for (int p = 0; p < NP; p++) begin
            rd(p, L + 6'd7, v); chk(v, 32'hFFFF_FFFF, "R1 compare");
            rd(p, L + 6'd0, v); chk(v, 32'h0, "R1 pending");
            rd(p, L + 6'd1, v); chk(v, 32'h32, "R1 mask");
            rd(p, L + 6'd4, v); chk(v, 32'h8000_0000, "R1 map");
            rd(p, L + 6'd5, v); chk(v, 32'h0, "R1 remote select");
        end
        rd(0, 6'h00, v); chk(v, 32'h0, "R1 halt bit");
        chk(32'(irq), 32'h0, "R1 irq");
        rd(0, 6'h01, v);
        repeat (10) @(negedge clk);
        rd(0, 6'h01, v2); chk(v2 - v, 32'd10, "R2 runs");
    endtask

    task automatic t_counter;
        logic [31:0] v;
        wr(0, 6'h00, 32'h1);
        rd(0, 6'h01, v);
        repeat (5) @(negedge clk);
        begin logic [31:0] v2; rd(0, 6'h01, v2); chk(v2, v, "R2 halted"); end
        wr(0, 6'h01, 32'd1000);
        rd(0, 6'h01, v); chk(v, 32'd1000, "R3 load while halted");
        wr(0, 6'h02, 32'd5);
        rd(0, 6'h02, v); chk(v, 32'h0, "R4 upper word");
        wr(0, 6'h03, 32'd77);
        rd(0, 6'h01, v); chk(v, 32'd1000, "R4 user copy write ignored");
        rd(0, 6'h03, v); chk(v, 32'd1000, "R4 user copy reads counter");
        wr(0, 6'h00, 32'h0);
        wr(0, 6'h01, 32'd5);
        wr(0, 6'h00, 32'h1);
        rd(0, 6'h01, v); chk(v, 32'd1002, "R3 write while running ignored");
    endtask

    task automatic t_match;
        logic [31:0] v;
        wr(0, L + 6'd7, 32'd1010);
        wr(0, 6'h00, 32'h0);
        repeat (8) @(negedge clk);
        rd(0, 6'h01, v); chk(v, 32'd1010, "R5 counter at match");
        chk(32'(irq[0]), 32'h0, "R5 not yet pending");
        @(negedge clk);
        chk(32'(irq[0]), 32'h1, "R6 pin 0 driven");
        rd(0, L + 6'd0, v); chk(v, 32'h2, "R5 pending bit 1");
        repeat (3) @(negedge clk);
        chk(32'(irq), 32'h1, "R5 pending sticky");
        wr(0, 6'h00, 32'h1);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(0, L + 6'd2, 32'h2);
        rd(0, L + 6'd1, v); chk(v, 32'h30, "R8 clear alias");
        chk(32'(irq[0]), 32'h0, "R6 masked");
        wr(0, L + 6'd1, 32'h0);
        rd(0, L + 6'd1, v); chk(v, 32'h30, "R8 direct write ignored");
        wr(0, L + 6'd3, 32'hFFFF_FFFF);
        rd(0, L + 6'd1, v); chk(v, 32'h3F, "R8 set alias");
        chk(32'(irq[0]), 32'h1, "R6 unmasked");
        wr(0, L + 6'd2, 32'h0D);
        rd(0, L + 6'd1, v); chk(v, 32'h32, "R8 partial clear");
    endtask

    task automatic t_shared;
        logic [31:0] v;
        shared_irq[0] = 1'b1;
        wr(0, L + 6'd7, 32'hFFFF_FFFF);
        rd(0, L + 6'd0, v); chk(v, 32'h0, "R7 pending cleared");
        chk(32'(irq[0]), 32'h1, "R12 shared keeps pin");
        shared_irq[0] = 1'b0; #1;
        chk(32'(irq), 32'h0, "R7 pin released");
        shared_irq[7] = 1'b1; #1;
        chk(32'(irq), 32'h80, "R12 shared pass-through");
        shared_irq[7] = 1'b0;
    endtask

    task automatic t_map;
        logic [31:0] v, c;
        wr(1, L + 6'd4, 32'h8000_0003);
        rd(1, 6'h01, c);
        wr(1, L + 6'd7, c);
        chk(32'(irq), 32'h0, "R5 one cycle after compare write");
        @(negedge clk);
        chk(32'(irq), 32'h200, "R6 processor 1 pin 3");
        wr(1, L + 6'd4, 32'h8000_0006);
        rd(1, L + 6'd4, v); chk(v, 32'h8000_0003, "R9 pin 6 ignored");
        chk(32'(irq), 32'h200, "R9 routing kept");
        wr(1, L + 6'd4, 32'h0000_0002);
        rd(1, L + 6'd4, v); chk(v, 32'h2, "R6 map without flag");
        chk(32'(irq), 32'h0, "R6 flag clear no drive");
    endtask

    task automatic t_remote;
        logic [31:0] v;
        wr(0, L + 6'd5, 32'h1);
        rd(0, L + 6'd5, v); chk(v, 32'h1, "R10 select stored");
        wr(0, L + 6'd5, 32'h2);
        rd(0, L + 6'd5, v); chk(v, 32'h1, "R10 select 2 ignored");
        rd(0, L + 6'd6, v); chk(v, 32'h0, "R11 local identity p0");
        rd(1, L + 6'd6, v); chk(v, 32'h1, "R11 local identity p1");
        rd(0, O + 6'd6, v); chk(v, 32'h1, "R11 remote identity");
        wr(0, O + 6'd7, 32'h1234);
        rd(1, L + 6'd7, v); chk(v, 32'h1234, "R10 remote compare write");
        rd(0, L + 6'd7, v); chk(v, 32'hFFFF_FFFF, "R10 own compare untouched");
        rd(1, L + 6'd0, v); chk(v, 32'h0, "R7 remote write clears pending");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_counter();
        t_match();
        t_mask();
        t_shared();
        t_map();
        t_remote();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule